// File: doc/BRIEF.md
# Transfer Descriptor Writeback Engine

This block serves a data transfer controller. Each time the controller is activated, the engine takes a transfer descriptor: a mode, source and destination addresses, a saved initial address, a count split into a reload half and a working half, and a block count. It performs the data moves through a simple memory port, one read followed by one write per unit. It then produces the updated descriptor to be stored back, together with a one-cycle interrupt request to the CPU.

Three modes are supported. Normal mode moves one unit and counts down. Repeat mode moves one unit per activation and reloads its count when a run ends. Block mode moves a whole block per activation. In repeat and block mode, a select bit marks either the source side or the destination side as the repeat/block area. That side's address is restored from the saved initial address when its run or block completes. The other side follows its own step rule.

Top module: `xfer_wb_engine`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `mem_rd` and `mem_wr` are low, and they stay low while no activation is in progress.
- R2: Normal mode (`cfg_mode`=0, and also 3) performs one read of `in_src` and then one write of the returned data to `in_dst`. Each address moves by 1, 2 or 4 bytes for `cfg_size` 0, 1 or 2. The move direction is set by its direction code: 0 fixed, 1 increment, 2 decrement. `wb_work` is `in_work`-1 and `wb_blocks` equals `in_blocks`.
- R3: In normal mode `irq` is raised only when `in_work` is 1. An `in_work` of 0 stands for 65536: it writes back 16'hFFFF and raises no interrupt.
- R4: In repeat mode (`cfg_mode`=1) only the low 8 bits of the working and reload counts are used. When the working count is not 1, `wb_work` is that count minus 1, zero-extended, and both addresses step. A working count of 0 stands for 256 and writes back 255.
- R5: In repeat mode, a working count of 1 ends the run. `wb_work` becomes the low 8 bits of `in_reload`, and the repeat-side address becomes `in_init`.
- R6: In repeat mode `irq` is raised only when the run ends and `cfg_rpt_irq` is 1.
- R7: `cfg_area_dst`=0 makes the source the repeat/block area; `cfg_area_dst`=1 makes the destination the area. The non-area address always steps by its own rule.
- R8: Block mode (`cfg_mode`=2) moves `in_reload` units per activation, where 0 means 65536. The area-side address is written back as `in_init`. The other side is written back after the full block of steps. `wb_work` equals `in_reload` and `wb_blocks` is `in_blocks`-1.
- R9: In block mode `irq` is raised only when `in_blocks` is 1.
- R10: `done` is high for exactly one cycle after the last write of an activation, and `irq` is high only together with `done`. A `start` that arrives while `busy` is ignored.
- R11: `mem_rd` and `mem_wr` are never high together, and every write cycle directly follows a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Activation request, taken only when idle |
| cfg_mode | input | 2 | 0 normal, 1 repeat, 2 block, 3 normal |
| cfg_size | input | 2 | Unit size: 0 byte, 1 word, 2 longword |
| cfg_src_dir | input | 2 | Source step: 0 fixed, 1 increment, 2 decrement |
| cfg_dst_dir | input | 2 | Destination step, same coding |
| cfg_area_dst | input | 1 | Area side: 0 source, 1 destination |
| cfg_rpt_irq | input | 1 | Interrupt enable for repeat-run end |
| in_src | input | AW | Source address |
| in_dst | input | AW | Destination address |
| in_init | input | AW | Saved initial address of the area side |
| in_reload | input | CW | Reload half / block length |
| in_work | input | CW | Working count |
| in_blocks | input | CW | Block count |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Memory address |
| mem_size | output | 2 | Unit size of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Activation in progress |
| done | output | 1 | One-cycle writeback complete pulse |
| irq | output | 1 | CPU interrupt request |
| wb_src | output | AW | Written-back source address |
| wb_dst | output | AW | Written-back destination address |
| wb_work | output | CW | Written-back working count |
| wb_blocks | output | CW | Written-back block count |

## Verification
The hardest case to reach is the end of a repeat run or a block. Here the area-side restore, the count reload and the interrupt masking all act in the same writeback, on whichever side the select bit names. The stimulus table places a descriptor directly at the boundary: a working count of 1 with each select value and each interrupt-enable value, and a block count of 1 against a count of 0. This way each end condition is reached in a single activation, without first counting a run down. A directed test raises `start` again in the middle of a multi-unit block to show that the second request is ignored.

// File: rtl/xwb_pkg.sv
package xwb_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_REPEAT = 2'd1,
    MD_BLOCK  = 2'd2,
    MD_RSVD   = 2'd3
  } xwb_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } xwb_state_t;

  localparam logic [1:0] DIR_INC = 2'd1;
  localparam logic [1:0] DIR_DEC = 2'd2;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/xwb_addr_step.sv
module xwb_addr_step
  import xwb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    dir,
  input  logic [1:0]    size,
  output logic [AW-1:0] next
);
  logic [AW-1:0] delta;

  assign delta = AW'(unit_bytes(size));

  always_comb begin
    case (dir)
      DIR_INC: next = addr + delta;
      DIR_DEC: next = addr - delta;
      default: next = addr;
    endcase
  end
endmodule

// File: rtl/xwb_count_calc.sv
module xwb_count_calc
  import xwb_pkg::*;
#(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  xwb_mode_t     mode,
  input  logic          rpt_irq_en,
  input  logic [CW-1:0] reload,
  input  logic [CW-1:0] work,
  input  logic [CW-1:0] blocks,
  output logic [CW-1:0] wb_work,
  output logic [CW-1:0] wb_blocks,
  output logic          run_end,
  output logic          irq_cond
);
  localparam int PADW = CW - RW;

  logic [RW-1:0] rwork;
  logic [RW-1:0] rwork_dec;

  assign rwork     = work[RW-1:0];
  assign rwork_dec = rwork - RW'(1);

  always_comb begin
    run_end   = 1'b0;
    wb_blocks = blocks;
    case (mode)
      MD_REPEAT: begin
        run_end  = (rwork == RW'(1));
        wb_work  = run_end ? {{PADW{1'b0}}, reload[RW-1:0]} : {{PADW{1'b0}}, rwork_dec};
        irq_cond = run_end && rpt_irq_en;
      end
      MD_BLOCK: begin
        wb_work   = reload;
        wb_blocks = blocks - CW'(1);
        irq_cond  = (blocks == CW'(1));
      end
      default: begin
        wb_work  = work - CW'(1);
        irq_cond = (work == CW'(1));
      end
    endcase
  end
endmodule

// File: rtl/xfer_wb_engine.sv
module xfer_wb_engine
  import xwb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_size,
  input  logic [1:0]    cfg_src_dir,
  input  logic [1:0]    cfg_dst_dir,
  input  logic          cfg_area_dst,
  input  logic          cfg_rpt_irq,
  input  logic [AW-1:0] in_src,
  input  logic [AW-1:0] in_dst,
  input  logic [AW-1:0] in_init,
  input  logic [CW-1:0] in_reload,
  input  logic [CW-1:0] in_work,
  input  logic [CW-1:0] in_blocks,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic [AW-1:0] wb_src,
  output logic [AW-1:0] wb_dst,
  output logic [CW-1:0] wb_work,
  output logic [CW-1:0] wb_blocks
);
  localparam int NSIDE = 2;

  xwb_state_t    state_q;
  xwb_mode_t     mode_q;
  logic [1:0]    size_q;
  logic [1:0]    dir_q  [NSIDE];
  logic [AW-1:0] addr_q [NSIDE];
  logic [AW-1:0] addr_nx[NSIDE];
  logic          area_q;
  logic          ien_q;
  logic [AW-1:0] init_q;
  logic [CW-1:0] reload_q, work_q, blocks_q, len_q;
  logic          irq_q;

  logic [CW-1:0] cw_work, cw_blocks;
  logic          run_end, irq_cond, restore, last_unit;
  logic [AW-1:0] fin_src, fin_dst;

  for (genvar g = 0; g < NSIDE; g++) begin : g_step
    xwb_addr_step #(.AW(AW)) u_step (
      .addr (addr_q[g]),
      .dir  (dir_q[g]),
      .size (size_q),
      .next (addr_nx[g])
    );
  end

  xwb_count_calc #(.CW(CW), .RW(RW)) u_count (
    .mode       (mode_q),
    .rpt_irq_en (ien_q),
    .reload     (reload_q),
    .work       (work_q),
    .blocks     (blocks_q),
    .wb_work    (cw_work),
    .wb_blocks  (cw_blocks),
    .run_end    (run_end),
    .irq_cond   (irq_cond)
  );

  assign last_unit = (len_q == CW'(1));
  assign restore   = (mode_q == MD_BLOCK) || ((mode_q == MD_REPEAT) && run_end);
  assign fin_src   = (restore && !area_q) ? init_q : addr_nx[0];
  assign fin_dst   = (restore &&  area_q) ? init_q : addr_nx[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mode_q    <= MD_NORMAL;
      size_q    <= '0;
      dir_q[0]  <= '0;
      dir_q[1]  <= '0;
      addr_q[0] <= '0;
      addr_q[1] <= '0;
      area_q    <= 1'b0;
      ien_q     <= 1'b0;
      init_q    <= '0;
      reload_q  <= '0;
      work_q    <= '0;
      blocks_q  <= '0;
      len_q     <= '0;
      irq_q     <= 1'b0;
      wb_src    <= '0;
      wb_dst    <= '0;
      wb_work   <= '0;
      wb_blocks <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q    <= xwb_mode_t'(cfg_mode);
            size_q    <= cfg_size;
            dir_q[0]  <= cfg_src_dir;
            dir_q[1]  <= cfg_dst_dir;
            addr_q[0] <= in_src;
            addr_q[1] <= in_dst;
            area_q    <= cfg_area_dst;
            ien_q     <= cfg_rpt_irq;
            init_q    <= in_init;
            reload_q  <= in_reload;
            work_q    <= in_work;
            blocks_q  <= in_blocks;
            len_q     <= (xwb_mode_t'(cfg_mode) == MD_BLOCK) ? in_reload : CW'(1);
            state_q   <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          if (last_unit) begin
            wb_src    <= fin_src;
            wb_dst    <= fin_dst;
            wb_work   <= cw_work;
            wb_blocks <= cw_blocks;
            irq_q     <= irq_cond;
            state_q   <= ST_DONE;
          end else begin
            addr_q[0] <= addr_nx[0];
            addr_q[1] <= addr_nx[1];
            len_q     <= len_q - CW'(1);
            state_q   <= ST_RD;
          end
        end
        default: begin
          irq_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign mem_rd    = (state_q == ST_RD);
  assign mem_wr    = (state_q == ST_WR);
  assign mem_addr  = (state_q == ST_WR) ? addr_q[1] : addr_q[0];
  assign mem_size  = size_q;
  assign mem_wdata = mem_rdata;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign irq       = irq_q;
endmodule

// File: rtl/xfer_wb_engine_chk.sv
module xfer_wb_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       irq,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [1:0] mode_q,
  input logic       ien_q
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_rd || mem_wr || done || irq));

  assert_rpt_irq_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == 2'd1 && !ien_q) |-> !irq);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_irq_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);

  assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_wr_after_rd_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(mem_rd));
endmodule

bind xfer_wb_engine xfer_wb_engine_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .done   (done),
  .irq    (irq),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .mode_q (mode_q),
  .ien_q  (ien_q)
);

// File: tb/xfer_wb_engine_tb.sv
module xfer_wb_engine_tb;
  typedef struct packed {
    logic [1:0]  mode, size, sdir, ddir;
    logic        area, ien;
    logic [31:0] src, dst, init;
    logic [15:0] reload, work, blocks;
    logic [31:0] e_src, e_dst;
    logic [15:0] e_work, e_blocks;
    logic        e_irq;
    logic [15:0] e_units;
  } vec_t;

  // mode,size,sdir,ddir,area,ien, src,dst,init, reload,work,blocks, e_src,e_dst,e_work,e_blocks,e_irq,e_units
  localparam vec_t VECS [0:10] = '{
    '{2'd0,2'd0,2'd1,2'd1,1'b0,1'b0, 32'h10,32'h80,32'h0,  16'd0,16'd5,16'd7, 32'h11,32'h81,16'd4,16'd7,1'b0,16'd1},      // R2
    '{2'd0,2'd1,2'd2,2'd0,1'b0,1'b0, 32'h20,32'h90,32'h0,  16'd0,16'd1,16'd7, 32'h1E,32'h90,16'd0,16'd7,1'b1,16'd1},      // R2 R3
    '{2'd0,2'd2,2'd0,2'd2,1'b0,1'b0, 32'h30,32'hA0,32'h0,  16'd0,16'd0,16'd7, 32'h30,32'h9C,16'hFFFF,16'd7,1'b0,16'd1},   // R3
    '{2'd1,2'd0,2'd1,2'd1,1'b0,1'b1, 32'h14,32'h84,32'h10, 16'd4,16'd3,16'd7, 32'h15,32'h85,16'd2,16'd7,1'b0,16'd1},      // R4
    '{2'd1,2'd0,2'd1,2'd1,1'b0,1'b1, 32'h14,32'h84,32'h10, 16'h1204,16'd1,16'd7, 32'h10,32'h85,16'd4,16'd7,1'b1,16'd1},   // R5 R6 R7
    '{2'd1,2'd0,2'd1,2'd1,1'b0,1'b0, 32'h14,32'h84,32'h10, 16'h1204,16'd1,16'd7, 32'h10,32'h85,16'd4,16'd7,1'b0,16'd1},   // R6
    '{2'd1,2'd1,2'd1,2'd1,1'b1,1'b1, 32'h40,32'hB4,32'hB0, 16'd3,16'd1,16'd7, 32'h42,32'hB0,16'd3,16'd7,1'b1,16'd1},      // R5 R7
    '{2'd1,2'd2,2'd1,2'd1,1'b1,1'b1, 32'h40,32'hB0,32'hB0, 16'd3,16'd0,16'd7, 32'h44,32'hB4,16'h00FF,16'd7,1'b0,16'd1},   // R4
    '{2'd2,2'd0,2'd1,2'd1,1'b1,1'b0, 32'h50,32'hC0,32'hC0, 16'd4,16'd0,16'd3, 32'h54,32'hC0,16'd4,16'd2,1'b0,16'd4},      // R8
    '{2'd2,2'd1,2'd1,2'd1,1'b0,1'b0, 32'h60,32'hD0,32'h60, 16'd3,16'd0,16'd1, 32'h60,32'hD6,16'd3,16'd0,1'b1,16'd3},      // R8 R9
    '{2'd2,2'd2,2'd2,2'd1,1'b1,1'b0, 32'h70,32'hE0,32'hE0, 16'd2,16'd0,16'd0, 32'h68,32'hE0,16'd2,16'hFFFF,1'b0,16'd2}    // R8 R9
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  cfg_mode = '0, cfg_size = '0, cfg_src_dir = '0, cfg_dst_dir = '0;
  logic        cfg_area_dst = 1'b0, cfg_rpt_irq = 1'b0;
  logic [31:0] in_src = '0, in_dst = '0, in_init = '0;
  logic [15:0] in_reload = '0, in_work = '0, in_blocks = '0;
  logic        mem_rd, mem_wr, busy, done, irq;
  logic [31:0] mem_addr, mem_wdata, wb_src, wb_dst;
  logic [31:0] mem_rdata = '0;
  logic [1:0]  mem_size;
  logic [15:0] wb_work, wb_blocks;
  logic [31:0] mem [0:255];

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  xfer_wb_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode), .cfg_size(cfg_size),
    .cfg_src_dir(cfg_src_dir), .cfg_dst_dir(cfg_dst_dir), .cfg_area_dst(cfg_area_dst),
    .cfg_rpt_irq(cfg_rpt_irq), .in_src(in_src), .in_dst(in_dst), .in_init(in_init),
    .in_reload(in_reload), .in_work(in_work), .in_blocks(in_blocks),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done), .irq(irq),
    .wb_src(wb_src), .wb_dst(wb_dst), .wb_work(wb_work), .wb_blocks(wb_blocks)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA500_0000 | i;
    end else begin
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cfg_mode = v.mode; cfg_size = v.size; cfg_src_dir = v.sdir; cfg_dst_dir = v.ddir;
    cfg_area_dst = v.area; cfg_rpt_irq = v.ien; in_src = v.src; in_dst = v.dst;
    in_init = v.init; in_reload = v.reload; in_work = v.work; in_blocks = v.blocks;
  endtask

  task automatic run_vec(input vec_t v, input int idx, input logic poke_busy);
    int writes = 0;
    int guard = 0;
    int overlap = 0;
    logic got = 1'b0;
    logic [31:0] fw_data = '0, fw_addr = '0;
    vec_t other;
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 150000) begin
      if (mem_rd && mem_wr) overlap++;
      if (mem_wr) begin
        writes++;
        if (!got) begin got = 1'b1; fw_data = mem_wdata; fw_addr = mem_addr; end
      end
      if (poke_busy && guard == 3) begin
        other = VECS[0];
        drive(other);
        start = 1'b1;
      end else start = 1'b0;
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 vector %0d done never seen actual=0 expected=1", idx);
      return;
    end
    chk("R2/R5/R7/R8", $sformatf("v%0d wb_src", idx), wb_src, v.e_src);
    chk("R2/R5/R7/R8", $sformatf("v%0d wb_dst", idx), wb_dst, v.e_dst);
    chk("R2/R4/R5/R8", $sformatf("v%0d wb_work", idx), {16'h0, wb_work}, {16'h0, v.e_work});
    chk("R2/R8", $sformatf("v%0d wb_blocks", idx), {16'h0, wb_blocks}, {16'h0, v.e_blocks});
    chk("R3/R6/R9", $sformatf("v%0d irq", idx), {31'h0, irq}, {31'h0, v.e_irq});
    chk("R8", $sformatf("v%0d write count", idx), writes, {16'h0, v.e_units});
    chk("R2", $sformatf("v%0d first write data", idx), fw_data, 32'hA500_0000 | v.src[7:0]);
    chk("R2", $sformatf("v%0d first write addr", idx), fw_addr, v.dst);
    chk("R11", $sformatf("v%0d rd/wr overlap", idx), overlap, 0);
    @(negedge clk);
    chk("R10", $sformatf("v%0d done one cycle", idx), {31'h0, done}, 32'h0);
    chk("R10", $sformatf("v%0d irq cleared", idx), {31'h0, irq}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    vec_t bv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy after reset", {31'h0, busy}, 0);
    chk("R1", "done after reset", {31'h0, done}, 0);
    chk("R1", "irq after reset", {31'h0, irq}, 0);
    chk("R1", "mem strobes after reset", {30'h0, mem_rd, mem_wr}, 0);

    for (int k = 0; k < 11; k++) run_vec(VECS[k], k, 1'b0);

    // R10: second start in the middle of an 8-unit block is ignored
    bv = '{2'd2,2'd0,2'd1,2'd1,1'b1,1'b0, 32'h08,32'hF0,32'hF0, 16'd8,16'd0,16'd5,
           32'h10,32'hF0,16'd8,16'd4,1'b0,16'd8};
    run_vec(bv, 11, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10", "no activation from ignored start", {31'h0, busy}, 0);
    chk("R1", "idle strobes quiet", {30'h0, mem_rd, mem_wr}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule